// File: doc/BRIEF.md
# Prioritized Interrupt Mask and Cause Unit

This unit gathers interrupt sources from outside devices and from internal exception events into eight priority levels and decides, each cycle, whether the processor should leave its current work to serve one of them. A status register holds a global enable bit and one enable bit per level. A cause register reports which levels are pending, which level is in service and how deeply handlers are nested. Software reaches both registers through a single register select, write strobe and registered read port.

When an interrupt is accepted, the unit clears the global enable. This blocks every further request until the handler has saved its state and sets the global enable again. While a level is in service, only strictly higher levels can break in. Each acceptance pushes the previous global enable and the previous in-service level onto a two-entry stack, and a return strobe pops them. A request can therefore be ignored because a higher level is being served, because state saving is not finished, or because the nesting stack is full.

Top module: `irq_ctl_unit`

## Requirements
- R1: After reset the status register reads zero, the cause register reads zero, `irq_take` is low and `in_service` is low.
- R2: Pending bits for device requests follow `ext_req` directly, so bit i of the cause read equals `ext_req[i]` as it was at the sampling edge. Writing ones to the cause register does not clear them.
- R3: A pulse on `exc_evt[i]` sets pending bit i, and that bit stays set until software writes a one to bit i of the cause register (register select 1). If an event and a clear of the same bit arrive in the same cycle, the bit stays set.
- R4: An interrupt is accepted only when its pending bit, its enable bit (status bit i+1) and the global enable (status bit 0) are all set. Among the accepted candidates the highest index wins, with level 7 the highest. `irq_take` is high for exactly one cycle per acceptance, and `irq_level` shows the accepted level in that cycle.
- R5: Acceptance clears the global enable. No further interrupt is accepted until software sets it again.
- R6: While a level is in service, only pending levels strictly above it are eligible. Equal and lower levels are ignored.
- R7: A return strobe restores the global enable and the in-service state that were stacked at the matching acceptance. A return strobe with an empty stack changes no register.
- R8: The nesting stack is two entries deep. With two handlers active, no interrupt is accepted.
- R9: A status write issued at one clock edge influences the decision only from the next edge on.
- R10: No interrupt is accepted at an edge where the return strobe is high. A request that is still eligible is taken at the following edge.
- R11: Cause read layout: pending in bits 7:0, in-service level in bits 10:8, in-service flag in bit 11, stack depth in bits 13:12. Status read layout: global enable in bit 0, level enables in bits 8:1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_req | input | 8 | Level-sensitive device requests, one per priority level |
| exc_evt | input | 8 | Internal exception event pulses, one per priority level |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 status, 1 cause |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data of the selected register |
| ret_strobe | input | 1 | Handler return, pops the nesting stack |
| irq_take | output | 1 | One-cycle acceptance pulse |
| irq_level | output | 3 | Level accepted, valid with irq_take |
| in_service | output | 1 | A handler is active |
| service_level | output | 3 | Level currently in service |

## Verification
The hardest state to reach from the ports is a full nesting stack with a higher request pending and the global enable set. Getting there means taking one interrupt, having software turn the global enable back on, and taking a second, higher one. The bench walks this chain with device requests and status writes. It then shows that a level-7 request waits until a return frees a stack slot, and that the request is not taken at the return edge itself. A sweep applies all 256 request patterns against varied enable masks from the idle state and predicts the winning level arithmetically.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;
  typedef enum logic {
    SEL_STATUS = 1'b0,
    SEL_CAUSE  = 1'b1
  } regsel_e;

  localparam int GIE_POS = 0;
endpackage

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
  parameter int NLVL = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sw_wr,
  input  logic [NLVL:0]   sw_data,
  input  logic            accept,
  input  logic            restore,
  input  logic            restore_gie,
  output logic            gie,
  output logic [NLVL-1:0] lvl_en
);
  import irq_ctl_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      gie    <= 1'b0;
      lvl_en <= '0;
    end else begin
      if (sw_wr)
        lvl_en <= sw_data[NLVL:1];
      if (restore)
        gie <= restore_gie;
      else if (accept)
        gie <= 1'b0;
      else if (sw_wr)
        gie <= sw_data[GIE_POS];
    end
  end
endmodule

// File: rtl/irq_pending.sv
module irq_pending #(
  parameter int NLVL = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NLVL-1:0] ext_req,
  input  logic [NLVL-1:0] exc_evt,
  input  logic            clr_wr,
  input  logic [NLVL-1:0] clr_mask,
  output logic [NLVL-1:0] pend
);
  logic [NLVL-1:0] exc_q;
  logic [NLVL-1:0] clr_vec;

  assign clr_vec = clr_wr ? clr_mask : '0;

  always_ff @(posedge clk) begin
    if (rst)
      exc_q <= '0;
    else
      exc_q <= (exc_q & ~clr_vec) | exc_evt;
  end

  assign pend = ext_req | exc_q;
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int NLVL = 8,
  parameter int LW   = 3
) (
  input  logic [NLVL-1:0] pend,
  input  logic [NLVL-1:0] lvl_en,
  input  logic            gie,
  input  logic            busy,
  input  logic [LW-1:0]   cur_lvl,
  input  logic            stack_full,
  output logic            go,
  output logic [LW-1:0]   go_lvl
);
  logic [NLVL-1:0] above;
  logic [NLVL-1:0] elig;

  for (genvar i = 0; i < NLVL; i++) begin : g_lvl
    assign above[i] = !busy || (LW'(i) > cur_lvl);
    assign elig[i]  = pend[i] & lvl_en[i] & above[i];
  end

  always_comb begin
    go_lvl = '0;
    for (int i = 0; i < NLVL; i++)
      if (elig[i]) go_lvl = LW'(i);
  end

  assign go = gie && (|elig) && !stack_full;
endmodule

// File: rtl/irq_nest_stack.sv
module irq_nest_stack #(
  parameter int DEPTH = 2,
  parameter int W     = 5,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] depth,
  output logic          full,
  output logic          empty
);
  logic [W-1:0] slot [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst)
        slot[i] <= '0;
      else if (push) begin
        if (i == 0) slot[i] <= din;
        else        slot[i] <= slot[(i == 0) ? 0 : i - 1];
      end else if (pop) begin
        if (i == DEPTH - 1) slot[i] <= '0;
        else                slot[i] <= slot[(i == DEPTH - 1) ? i : i + 1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      depth <= '0;
    else if (push && !full)
      depth <= depth + 1'b1;
    else if (pop && !empty)
      depth <= depth - 1'b1;
  end

  assign dout  = slot[0];
  assign full  = (depth == CW'(DEPTH));
  assign empty = (depth == '0);
endmodule

// File: rtl/irq_ctl_unit.sv
module irq_ctl_unit #(
  parameter int NLVL  = 8,
  parameter int DEPTH = 2,
  parameter int DW    = 16,
  parameter int LW    = $clog2(NLVL),
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NLVL-1:0] ext_req,
  input  logic [NLVL-1:0] exc_evt,
  input  logic            reg_wr,
  input  logic            reg_sel,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  input  logic            ret_strobe,
  output logic            irq_take,
  output logic [LW-1:0]   irq_level,
  output logic            in_service,
  output logic [LW-1:0]   service_level
);
  import irq_ctl_pkg::*;

  localparam int FW      = LW + 2;
  localparam int SVC_POS = NLVL;
  localparam int BSY_POS = NLVL + LW;
  localparam int DEP_POS = NLVL + LW + 1;

  logic            gie;
  logic [NLVL-1:0] lvl_en;
  logic [NLVL-1:0] pend;
  logic [CW-1:0]   depth;
  logic            stk_full, stk_empty;
  logic [FW-1:0]   stk_out;
  logic            go;
  logic [LW-1:0]   go_lvl;
  logic            accept, restore;
  logic            wr_status, wr_cause;
  logic [DW-1:0]   status_view, cause_view;

  assign wr_status = reg_wr && (reg_sel == SEL_STATUS);
  assign wr_cause  = reg_wr && (reg_sel == SEL_CAUSE);
  assign restore   = ret_strobe && !stk_empty;
  assign accept    = go && !ret_strobe;

  irq_status_reg #(.NLVL(NLVL)) u_status (
    .clk(clk), .rst(rst),
    .sw_wr(wr_status), .sw_data(reg_wdata[NLVL:0]),
    .accept(accept), .restore(restore), .restore_gie(stk_out[FW-1]),
    .gie(gie), .lvl_en(lvl_en)
  );

  irq_pending #(.NLVL(NLVL)) u_pend (
    .clk(clk), .rst(rst),
    .ext_req(ext_req), .exc_evt(exc_evt),
    .clr_wr(wr_cause), .clr_mask(reg_wdata[NLVL-1:0]),
    .pend(pend)
  );

  irq_arbiter #(.NLVL(NLVL), .LW(LW)) u_arb (
    .pend(pend), .lvl_en(lvl_en), .gie(gie),
    .busy(in_service), .cur_lvl(service_level),
    .stack_full(stk_full), .go(go), .go_lvl(go_lvl)
  );

  irq_nest_stack #(.DEPTH(DEPTH), .W(FW), .CW(CW)) u_stack (
    .clk(clk), .rst(rst),
    .push(accept), .pop(restore),
    .din({gie, in_service, service_level}),
    .dout(stk_out), .depth(depth),
    .full(stk_full), .empty(stk_empty)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      in_service    <= 1'b0;
      service_level <= '0;
      irq_take      <= 1'b0;
      irq_level     <= '0;
    end else begin
      irq_take <= accept;
      if (accept) begin
        in_service    <= 1'b1;
        service_level <= go_lvl;
        irq_level     <= go_lvl;
      end else if (restore) begin
        in_service    <= stk_out[LW];
        service_level <= stk_out[LW-1:0];
      end
    end
  end

  always_comb begin
    status_view = '0;
    status_view[GIE_POS]  = gie;
    status_view[NLVL:1]   = lvl_en;
    cause_view = '0;
    cause_view[NLVL-1:0]           = pend;
    cause_view[SVC_POS +: LW]      = service_level;
    cause_view[BSY_POS]            = in_service;
    cause_view[DEP_POS +: CW]      = depth;
  end

  always_ff @(posedge clk) begin
    if (rst)
      reg_rdata <= '0;
    else
      reg_rdata <= (reg_sel == SEL_CAUSE) ? cause_view : status_view;
  end
endmodule

// File: rtl/irq_ctl_unit_chk.sv
module irq_ctl_unit_chk #(
  parameter int NLVL  = 8,
  parameter int DEPTH = 2,
  parameter int LW    = 3,
  parameter int CW    = 2
) (
  input logic            clk,
  input logic            rst,
  input logic            irq_take,
  input logic [LW-1:0]   irq_level,
  input logic            in_service,
  input logic [LW-1:0]   service_level,
  input logic            ret_strobe,
  input logic            gie,
  input logic [NLVL-1:0] lvl_en,
  input logic [NLVL-1:0] pend,
  input logic [CW-1:0]   depth
);
  logic [NLVL-1:0] cand_q;

  always_ff @(posedge clk) begin
    if (rst) cand_q <= '0;
    else     cand_q <= pend & lvl_en & {NLVL{gie}};
  end

  // R4
  take_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    irq_take |=> !irq_take);

  // R4
  take_qualified_chk: assert property (@(posedge clk) disable iff (rst)
    irq_take |-> cand_q[irq_level]);

  // R5
  gie_cleared_chk: assert property (@(posedge clk) disable iff (rst)
    irq_take |-> !gie);

  // R6
  higher_only_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_take && $past(in_service)) |-> (irq_level > $past(service_level)));

  // R8
  depth_bound_chk: assert property (@(posedge clk) disable iff (rst)
    depth <= CW'(DEPTH));

  // R8
  full_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    (depth == CW'(DEPTH)) |=> !irq_take);

  // R10
  ret_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    ret_strobe |=> !irq_take);
endmodule

bind irq_ctl_unit irq_ctl_unit_chk #(
  .NLVL(NLVL), .DEPTH(DEPTH), .LW(LW), .CW(CW)
) u_chk (
  .clk(clk), .rst(rst), .irq_take(irq_take), .irq_level(irq_level),
  .in_service(in_service), .service_level(service_level),
  .ret_strobe(ret_strobe), .gie(gie), .lvl_en(lvl_en),
  .pend(pend), .depth(depth)
);

// File: tb/sim_irq_ctl_unit.sv
module sim_irq_ctl_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  ext_req = '0;
  logic [7:0]  exc_evt = '0;
  logic        reg_wr = 1'b0;
  logic        reg_sel = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        ret_strobe = 1'b0;
  logic        irq_take;
  logic [2:0]  irq_level;
  logic        in_service;
  logic [2:0]  service_level;

  int vectors = 0;
  int misses  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  irq_ctl_unit u0 (
    .clk(clk), .rst(rst), .ext_req(ext_req), .exc_evt(exc_evt),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .ret_strobe(ret_strobe),
    .irq_take(irq_take), .irq_level(irq_level),
    .in_service(in_service), .service_level(service_level)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(logic sel, logic [15:0] d);
    reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
    tick();
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic wr_status(logic [7:0] en, logic g);
    wr_reg(1'b0, {7'd0, en, g});
  endtask

  task automatic rd_reg(logic sel, output logic [15:0] v);
    reg_sel = sel;
    tick();
    v = reg_rdata;
  endtask

  task automatic do_ret();
    ret_strobe = 1'b1;
    tick();
    ret_strobe = 1'b0;
  endtask

  function automatic int top_bit(logic [7:0] v);
    int r = -1;
    for (int i = 0; i < 8; i++) if (v[i]) r = i;
    return r;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      misses++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    logic [7:0]  en, pat;
    int          exp_lvl;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 take", int'(irq_take), 0);
    check("R1 in_service", int'(in_service), 0);
    rd_reg(1'b0, v); check("R1 status", int'(v), 0);
    rd_reg(1'b1, v); check("R1 cause", int'(v), 0);

    // R3 exception latch and write-one-to-clear, R2 external bits
    wr_status(8'h00, 1'b0);
    exc_evt = 8'h10; tick(); exc_evt = '0;
    rd_reg(1'b1, v); check("R3 latched", int'(v[7:0]), 'h10);
    tick(); tick();
    rd_reg(1'b1, v); check("R3 held", int'(v[7:0]), 'h10);
    ext_req = 8'h02;
    exc_evt = 8'h10;
    wr_reg(1'b1, 16'h0012);
    exc_evt = '0;
    rd_reg(1'b1, v); check("R3 set wins / R2 ext not cleared", int'(v[7:0]), 'h12);
    wr_reg(1'b1, 16'h0010);
    rd_reg(1'b1, v); check("R3 cleared", int'(v[7:0]), 'h02);
    ext_req = 8'h00;
    rd_reg(1'b1, v); check("R2 follows input", int'(v[7:0]), 'h00);

    // R4 sweep over all request patterns from idle
    for (int k = 0; k < 256; k++) begin
      pat = 8'(k);
      en  = 8'((k * 29 + 7) ^ (k >> 2));
      if (k % 4 == 0) en = 8'hFF;
      wr_status(en, 1'b1);
      ext_req = pat;
      tick();
      exp_lvl = top_bit(pat & en);
      check("R4 take", int'(irq_take), (exp_lvl >= 0) ? 1 : 0);
      if (exp_lvl >= 0) begin
        check("R4 level", int'(irq_level), exp_lvl);
        check("R4 service", int'(service_level), exp_lvl);
        ext_req = '0;
        do_ret();
        check("R4 pulse ends", int'(irq_take), 0);
        check("R7 idle after return", int'(in_service), 0);
      end
      ext_req = '0;
    end

    // R5, R6, R8, R7: nesting chain
    wr_status(8'hFF, 1'b1);
    ext_req = 8'h08; tick();
    check("R4 first take", int'(irq_take), 1);
    check("R4 first level", int'(irq_level), 3);
    ext_req = 8'h2C; tick();
    check("R5 blocked while saving", int'(irq_take), 0);
    rd_reg(1'b0, v); check("R5 gie cleared", int'(v[0]), 0);
    wr_status(8'hFF, 1'b1);
    check("R9 write not yet in effect", int'(irq_take), 0);
    tick();
    check("R6 higher taken", int'(irq_take), 1);
    check("R6 level above lower pending", int'(irq_level), 5);
    rd_reg(1'b1, v);
    check("R11 depth field", int'(v[13:12]), 2);
    check("R11 service field", int'(v[10:8]), 5);
    check("R11 busy field", int'(v[11]), 1);
    wr_status(8'hFF, 1'b1);
    ext_req = 8'hAC;
    tick(); check("R8 full stack blocks", int'(irq_take), 0);
    tick(); check("R8 still blocked", int'(irq_take), 0);
    do_ret();
    check("R10 no take on return edge", int'(irq_take), 0);
    check("R7 restored level", int'(service_level), 3);
    check("R7 restored busy", int'(in_service), 1);
    tick();
    check("R8 slot free take", int'(irq_take), 1);
    check("R8 level", int'(irq_level), 7);
    ext_req = '0;
    do_ret(); do_ret();
    check("R7 fully unwound", int'(in_service), 0);
    rd_reg(1'b0, v); check("R7 gie restored", int'(v[0]), 1);

    // R6 equal level ignored
    ext_req = 8'h08; tick();
    check("R6 setup take", int'(irq_take), 1);
    wr_status(8'hFF, 1'b1);
    ext_req = 8'h0F; tick(); tick();
    check("R6 equal and lower ignored", int'(irq_take), 0);

    // R10 return and request at the same edge
    ext_req = 8'h48; ret_strobe = 1'b1; tick(); ret_strobe = 1'b0;
    check("R10 suppressed", int'(irq_take), 0);
    check("R10 popped", int'(in_service), 0);
    tick();
    check("R10 taken next edge", int'(irq_take), 1);
    check("R10 level", int'(irq_level), 6);
    ext_req = '0; do_ret();

    // R7 return with empty stack
    wr_status(8'h3C, 1'b0);
    do_ret();
    rd_reg(1'b0, v); check("R7 empty return status", int'(v), 'h78);
    rd_reg(1'b1, v); check("R7 empty return cause", int'(v), 0);

    // R9 status write timing
    wr_status(8'h00, 1'b0);
    ext_req = 8'h04; tick();
    check("R9 disabled", int'(irq_take), 0);
    wr_status(8'h04, 1'b1);
    check("R9 old status used", int'(irq_take), 0);
    tick();
    check("R9 new status used", int'(irq_take), 1);
    check("R9 level", int'(irq_level), 2);
    ext_req = '0; do_ret();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule